// File: doc/BRIEF.md
# Parallel-to-Serial Output Converter with Enable Path

The block turns a parallel data word into a serial bit stream on one output pin. It uses two clocks: a fast bit clock, and a divided clock that is edge-aligned with it. On every rising edge of the divided clock it captures a new word. Starting at the next rising edge of the divided clock, it sends that word out bit by bit, lowest index first. Words follow each other with no gap.

The data path runs at single rate or at double rate. At single rate it sends one bit per fast cycle. At double rate it sends two bits per fast cycle, one while the fast clock is high and one while it is low.

A second path carries the output-enable bits for the pin driver. It can pass its enable bit straight through. It can also serialize one enable bit per word, or four enable bits per word, using the same slot timing as the data.

Power-up values and synchronous-reset values can be set separately for each output. Every illegal mix of width, rate and enable mode stops elaboration.

Top module: `par2ser_out`

## Requirements
- R1: In single-rate data mode, the serial output changes only on fast rising edges. The k-th fast cycle after a word is loaded (k counted from 0) carries bit k. Bit 0 goes out first, and the next word's bit 0 follows right after bit DATA_W-1.
- R2: In double-rate data mode, slot k of a word lasts one fast cycle. It shows bit 2k while the fast clock is high and bit 2k+1 while it is low.
- R3: A word present on `d_par` at a rising edge of `clk_div` is captured there. Its bit 0 appears right after the next rising edge of `clk_div`, which must coincide with a fast rising edge.
- R4: Legal data widths are 4, 6, 8 and 10 at double rate, and 2 through 8 at single rate. Any other width stops elaboration with a fatal message.
- R5: The enable width may be 1 in every mode. It may be 4 only when the data path is double rate, the enable path is double rate and DATA_W is 4. Any other enable width stops elaboration.
- R6: In buffered enable mode (mode code 0), `t_ser` always equals `t_par[0]`, including during reset.
- R7: In serial enable modes (code 1 single rate, code 2 double rate), `t_ser` follows the same word timing as the data. With width 1, the captured bit is held for the whole word. With width 4, bit i of `t_par` covers the same serial position as data bit i.
- R8: Before the first fast clock edge, `d_ser` shows INIT_D and `t_ser` shows INIT_T. Buffered enable mode is the exception: there, `t_ser` shows `t_par[0]` as R6 requires.
- R9: A fast edge with `rst` high drives `d_ser` to RST_D and a serialized `t_ser` to RST_T in both clock phases, even when that edge would have loaded a word. After `rst` is released on a `clk_div` rising edge, the stream restarts at bit 0 of the word captured one divided cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast bit clock |
| clk_div | input | 1 | Divided word clock, edge-aligned with clk_fast |
| rst | input | 1 | Synchronous reset, sampled on clk_fast |
| d_par | input | DATA_W | Parallel data word |
| t_par | input | TRI_W | Parallel output-enable bits |
| d_ser | output | 1 | Serial data output |
| t_ser | output | 1 | Serial or buffered enable output |

## Verification
Reset and word load can land on the same fast edge, because every load edge is also a possible reset edge. The sweep raises `rst` exactly on a load edge and holds it for two words. It also raises `rst` in the middle of a word and releases it on an aligned divided edge. The expected outputs are the reset values in both clock phases of every reset edge. After release, the stream must resume at bit 0 of the word the bench computes for that divided cycle, with no stale bits left from the word that was cut off.

// File: rtl/p2s_pkg.sv
package p2s_pkg;

  typedef enum logic [1:0] {
    TRI_BUF = 2'd0,
    TRI_SDR = 2'd1,
    TRI_DDR = 2'd2
  } tri_mode_e;

  // fast cycles needed to send one word
  function automatic int slots_per_word(int width, bit ddr);
    return ddr ? width / 2 : width;
  endfunction

  function automatic bit data_w_ok(int width, bit ddr);
    if (ddr) return (width == 4) || (width == 6) || (width == 8) || (width == 10);
    return (width >= 2) && (width <= 8);
  endfunction

  function automatic bit en_w_ok(tri_mode_e mode, int en_w, int width, bit ddr);
    if (en_w == 1) return 1'b1;
    return (en_w == 4) && (mode == TRI_DDR) && ddr && (width == 4);
  endfunction

endpackage

// File: rtl/p2s_slot_ctr.sv
module p2s_slot_ctr #(
  parameter int SLOTS = 2,
  localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] slot,
  output logic          load
);

  logic [CW-1:0] slot_q = '0;
  logic          at_last;

  assign at_last = (slot_q == CW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst)          slot_q <= '0;
    else if (at_last) slot_q <= '0;
    else              slot_q <= slot_q + CW'(1);
  end

  assign slot = slot_q;
  assign load = !rst && (slot_q == '0);

  // R1
  slot_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot_q <= CW'(SLOTS - 1));

  // R3
  load_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

endmodule

// File: rtl/p2s_lane.sv
module p2s_lane #(
  parameter int W        = 4,
  parameter int SLOTS    = 2,
  parameter bit DDR_MAP  = 1'b1,
  parameter bit DDR_OUT  = 1'b1,
  parameter bit INIT     = 1'b0,
  parameter bit RSTV     = 1'b0,
  parameter bit HOLD_CHK = 1'b0,
  localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] slot,
  input  logic          load,
  input  logic [W-1:0]  word_in,
  output logic          ser
);

  logic [W-1:0]  word_q = '0;
  logic [W-1:0]  src;
  logic [IW-1:0] idx_a, idx_b;
  logic [1:0]    pair_d;
  logic [1:0]    pair_q = {2{INIT}};

  generate
    if (DDR_MAP) begin : g_pair_map
      assign idx_a = IW'({slot, 1'b0});
      assign idx_b = IW'({slot, 1'b1});
    end else begin : g_single_map
      assign idx_a = IW'(slot);
      assign idx_b = IW'(slot);
    end
  endgenerate

  assign src    = load ? word_in : word_q;
  assign pair_d = {src[idx_b], src[idx_a]};

  always_ff @(posedge clk) begin
    if (load) word_q <= word_in;
  end

  always_ff @(posedge clk) begin
    if (rst) pair_q <= {2{RSTV}};
    else     pair_q <= pair_d;
  end

  generate
    if (DDR_OUT) begin : g_both_edges
      assign ser = clk ? pair_q[0] : pair_q[1];
    end else begin : g_rise_only
      assign ser = pair_q[0];
    end
  endgenerate

  // R9
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pair_q == {2{RSTV}}));

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (pair_q[0] == $past(word_in[0])));

  generate
    if (HOLD_CHK) begin : g_hold
      // R7
      enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (slot != '0) |=> $stable(pair_q));
    end
  endgenerate

endmodule

// File: rtl/par2ser_out.sv
module par2ser_out
  import p2s_pkg::*;
#(
  parameter int        DATA_W   = 4,
  parameter bit        DATA_DDR = 1'b1,
  parameter tri_mode_e TRI_MODE = TRI_DDR,
  parameter int        TRI_W    = 4,
  parameter bit        INIT_D   = 1'b0,
  parameter bit        INIT_T   = 1'b0,
  parameter bit        RST_D    = 1'b0,
  parameter bit        RST_T    = 1'b0
) (
  input  logic              clk_fast,
  input  logic              clk_div,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_par,
  input  logic [TRI_W-1:0]  t_par,
  output logic              d_ser,
  output logic              t_ser
);

  localparam int SLOTS = slots_per_word(DATA_W, DATA_DDR);
  localparam int CW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // R4
  if (!data_w_ok(DATA_W, DATA_DDR)) begin : g_bad_width
    $fatal(1, "par2ser_out: DATA_W not legal for the selected data rate");
  end
  // R5
  if (!en_w_ok(TRI_MODE, TRI_W, DATA_W, DATA_DDR)) begin : g_bad_en_width
    $fatal(1, "par2ser_out: TRI_W not legal for this mode combination");
  end

  logic [DATA_W-1:0] d_hold = '0;
  logic [TRI_W-1:0]  t_hold = '0;
  logic [CW-1:0]     slot;
  logic              load;

  always_ff @(posedge clk_div) begin
    d_hold <= d_par;
    t_hold <= t_par;
  end

  p2s_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk  (clk_fast),
    .rst  (rst),
    .slot (slot),
    .load (load)
  );

  p2s_lane #(
    .W(DATA_W), .SLOTS(SLOTS), .DDR_MAP(DATA_DDR), .DDR_OUT(DATA_DDR),
    .INIT(INIT_D), .RSTV(RST_D), .HOLD_CHK(1'b0)
  ) u_data (
    .clk     (clk_fast),
    .rst     (rst),
    .slot    (slot),
    .load    (load),
    .word_in (d_hold),
    .ser     (d_ser)
  );

  generate
    if (TRI_MODE == TRI_BUF) begin : g_en_buf
      assign t_ser = t_par[0];
    end else begin : g_en_ser
      logic [DATA_W-1:0] t_word;
      if (TRI_W == 1) begin : g_spread
        assign t_word = {DATA_W{t_hold[0]}};
      end else begin : g_direct
        assign t_word = t_hold;
      end
      p2s_lane #(
        .W(DATA_W), .SLOTS(SLOTS), .DDR_MAP(DATA_DDR),
        .DDR_OUT(TRI_MODE == TRI_DDR), .INIT(INIT_T), .RSTV(RST_T),
        .HOLD_CHK(TRI_W == 1)
      ) u_en (
        .clk     (clk_fast),
        .rst     (rst),
        .slot    (slot),
        .load    (load),
        .word_in (t_word),
        .ser     (t_ser)
      );
    end
  endgenerate

endmodule

// File: tb/test_par2ser_out.sv
module p2s_run #(
  parameter int CFG = 0,
  parameter int W   = 4,
  parameter int DDR = 1,
  parameter int TM  = 2,
  parameter int TW  = 4,
  parameter int ID  = 0,
  parameter int IT  = 0,
  parameter int RD  = 0,
  parameter int RT  = 0
) (
  input  logic clk,
  output int   n_chk,
  output int   n_bad,
  output logic done
);

  localparam int   S   = (DDR != 0) ? W / 2 : W;
  localparam int   E0  = 2 * S;
  localparam int   NE  = E0 + S * ((1 << W) + 12);
  localparam logic IDB = 1'(ID);
  localparam logic ITB = 1'(IT);
  localparam logic RDB = 1'(RD);
  localparam logic RTB = 1'(RT);

  logic          clk_div = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  d_par = '0;
  logic [TW-1:0] t_par = '0;
  logic          d_ser, t_ser;
  logic          r_at;
  int            ecnt = 0;

  par2ser_out #(
    .DATA_W(W), .DATA_DDR(1'(DDR)), .TRI_MODE(p2s_pkg::tri_mode_e'(TM)),
    .TRI_W(TW), .INIT_D(IDB), .INIT_T(ITB), .RST_D(RDB), .RST_T(RTB)
  ) i_par2ser_out (
    .clk_fast (clk),
    .clk_div  (clk_div),
    .rst      (rst),
    .d_par    (d_par),
    .t_par    (t_par),
    .d_ser    (d_ser),
    .t_ser    (t_ser)
  );

  // divided clock: rising on fast edges 0, S, 2S, ...
  initial forever begin
    @(posedge clk);
    clk_div = (ecnt % S == 0);
    ecnt++;
  end

  function automatic logic [W-1:0] word_of(int j);
    if (j < 0) return '0;
    return W'(j * 173 + 3);
  endfunction

  function automatic logic [TW-1:0] tword_of(int j);
    if (j < 0) return '0;
    return TW'(j * 5 + 1);
  endfunction

  function automatic logic rst_for(int e);
    return (e < E0) || (e >= E0 + 3*S && e < E0 + 5*S) ||
           (e >= E0 + 7*S + 1 && e < E0 + 9*S);
  endfunction

  task automatic chk(string tag, int e, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cfg=%0d edge=%0d got=%b exp=%b", tag, CFG, e, got, exp);
    end
  endtask

  task automatic check_phase(int e, logic r, int ph);
    int c, j, idx;
    logic [W-1:0]  wd;
    logic [TW-1:0] wt;
    if (r) begin
      chk("R9", e, d_ser, RDB);
      if (TM != 0) chk("R9", e, t_ser, RTB);
    end else begin
      c   = (e - E0) % S;
      j   = (e - E0) / S;
      idx = (DDR != 0) ? 2*c + ph : c;
      wd  = word_of(j) >> idx;
      chk((DDR != 0) ? "R2 R3" : "R1 R3", e, d_ser, wd[0]);
      if (TM != 0) begin
        wt = (TW == 1) ? tword_of(j) : (tword_of(j) >> idx);
        chk("R7", e, t_ser, wt[0]);
      end
    end
    if (TM == 0) chk("R6", e, t_ser, t_par[0]);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    #5;
    chk("R8", -1, d_ser, IDB);
    if (TM == 0) chk("R6", -1, t_ser, t_par[0]);
    else         chk("R8", -1, t_ser, ITB);
    for (int e = 0; e < NE; e++) begin
      @(posedge clk);
      r_at = rst;
      #5;
      check_phase(e, r_at, 0);
      @(negedge clk);
      #5;
      check_phase(e, r_at, 1);
      rst = rst_for(e + 1);
      if ((e + 1) % S == 0) begin
        d_par = word_of((e + 1 - S) / S);
        t_par = tword_of((e + 1 - S) / S);
      end
    end
    done = 1'b1;
  end

endmodule

module test_par2ser_out;

  localparam int NCFG = 11;
  localparam int C_W  [NCFG] = '{4, 6, 8, 10, 2, 3, 4, 5, 6, 7, 8};
  localparam int C_DDR[NCFG] = '{1, 1, 1, 1,  0, 0, 0, 0, 0, 0, 0};
  localparam int C_TM [NCFG] = '{2, 0, 1, 2,  1, 2, 0, 1, 2, 1, 1};
  localparam int C_TW [NCFG] = '{4, 1, 1, 1,  1, 1, 1, 1, 1, 1, 1};
  localparam int C_ID [NCFG] = '{0, 1, 0, 1,  1, 0, 1, 0, 1, 0, 1};
  localparam int C_IT [NCFG] = '{0, 0, 1, 1,  0, 1, 1, 0, 0, 1, 1};
  localparam int C_RD [NCFG] = '{0, 1, 1, 0,  0, 1, 1, 1, 0, 0, 1};
  localparam int C_RT [NCFG] = '{0, 0, 1, 1,  1, 0, 1, 1, 0, 1, 0};

  logic clk = 1'b0;
  initial forever #10 clk = ~clk;

  int              chk_v [NCFG];
  int              bad_v [NCFG];
  logic [NCFG-1:0] done_v;
  int              n_chk = 0;
  int              n_bad = 0;

  for (genvar g = 0; g < NCFG; g++) begin : g_run
    p2s_run #(
      .CFG(g), .W(C_W[g]), .DDR(C_DDR[g]), .TM(C_TM[g]), .TW(C_TW[g]),
      .ID(C_ID[g]), .IT(C_IT[g]), .RD(C_RD[g]), .RT(C_RT[g])
    ) u_run (
      .clk   (clk),
      .n_chk (chk_v[g]),
      .n_bad (bad_v[g]),
      .done  (done_v[g])
    );
  end

  task automatic own_chk(string tag, int a, int b, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s args=%0d/%0d got=%b exp=%b", tag, a, b, got, exp);
    end
  endtask

  initial begin
    int cyc;
    // R4: width legality per rate
    for (int w = 1; w <= 12; w++) begin
      own_chk("R4", w, 1, p2s_pkg::data_w_ok(w, 1'b1),
              (w % 2 == 0) && w >= 4 && w <= 10);
      own_chk("R4", w, 0, p2s_pkg::data_w_ok(w, 1'b0), w >= 2 && w <= 8);
    end
    // R5: enable width legality
    for (int m = 0; m < 3; m++) begin
      for (int w = 2; w <= 10; w++) begin
        own_chk("R5", m, w, p2s_pkg::en_w_ok(p2s_pkg::tri_mode_e'(m), 1, w, 1'b0), 1'b1);
        own_chk("R5", m, w, p2s_pkg::en_w_ok(p2s_pkg::tri_mode_e'(m), 4, w, 1'b1),
                (m == 2) && (w == 4));
        own_chk("R5", m, w, p2s_pkg::en_w_ok(p2s_pkg::tri_mode_e'(m), 4, w, 1'b0), 1'b0);
      end
    end
    cyc = 0;
    while (!(&done_v) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(&done_v)) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: runs finished=%b expected all ones", done_v);
    end
    for (int g = 0; g < NCFG; g++) begin
      n_chk += chk_v[g];
      n_bad += bad_v[g];
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule